// File: doc/BRIEF.md
# Multi-Port Receive Burst Scheduler

This block is the receive-side push engine of a multi-port physical-layer device. Several per-port receive FIFOs share one 32-bit bus toward a link-layer device. The engine watches each FIFO's stored byte count and whether it holds a complete packet end. It picks an eligible port in round-robin order and names that port in a single address cycle. It then streams a bounded burst of words from that port, marking packet start, packet end, byte modulo and error on the words.

The link layer throttles the bus with an active-low read enable. On any clock edge where that enable is high, nothing advances and every output keeps its value. The FIFO storage itself sits outside the block. It supplies a byte count and an end-of-packet flag for each port, and it offers the head word of the port named by `rd_port` over a valid/ready pair. A word leaves the FIFO on each rising edge where `hd_valid` and `hd_ready` are both high. `hd_ready` does not depend on `hd_valid`. It is high only during the data phase of a burst, and only while `renb_n` is low.

Top module: `rx_burst_sched`

## Requirements
- R1: A port is eligible only when its byte count is strictly greater than `cfg_thresh` or its `port_has_eop` bit is set. A count equal to the threshold with no packet end is not served.
- R2: Every burst opens with one address cycle: `rx_sx`=1, `rx_val`=0, and `rx_dat` holds the port number in bits 7:0, with bit 0 as the LSB and bits 31:8 zero.
- R3: A burst closes after the word that carries packet end, or after `cfg_burst_words` words (1 to 64; 0 means 64), whichever comes first. The next burst goes to the first eligible port after the last one served, wrapping from the highest port to port 0.
- R4: When `renb_n` is sampled high, all outputs hold their previous values and no FIFO word is consumed. When it is sampled low, the outputs advance on that edge.
- R5: If the selected FIFO runs empty mid-burst, `rx_val` goes low. Once data returns, the same port resumes with no new address cycle.
- R6: With `cfg_gap2`=0, the next address cycle follows the last data word directly. With `cfg_gap2`=1, exactly two idle cycles lie between them.
- R7: On the packet-end word, `rx_mod` gives the valid bytes: 00 means 4, 01 means bits 31:8, 10 means bits 31:16, and 11 means bits 31:24 only. On every other valid word, `rx_mod` is 00.
- R8: `rx_err` is high only on a valid packet-end word. A one-byte packet shows `rx_sop` and `rx_eop` on the same word.
- R9: `rx_prty` is odd parity over `rx_dat` on address and data cycles.
- R10: A packet cut by the burst limit continues in a later burst. `rx_sop` is set only on the packet's true first word.
- R11: Reset sets the round-robin pointer to port 0 and drives `rx_val` and `rx_sx` low.
- R12: `hd_ready` is low whenever `renb_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_thresh | input | CNTW | Byte-count threshold for eligibility |
| cfg_burst_words | input | LIMW | Maximum number of data words per burst |
| cfg_gap2 | input | 1 | 1 selects a two-cycle idle gap between bursts |
| port_bytes | input | NPORTS*CNTW | Stored byte count of each port, packed |
| port_has_eop | input | NPORTS | Port holds at least one complete packet end |
| rd_port | output | PW | Port whose head word is presented |
| hd_valid | input | 1 | Head word of `rd_port` is present |
| hd_ready | output | 1 | Engine takes the head word on this edge |
| hd_data | input | 32 | Head word data |
| hd_sop | input | 1 | Head word is a packet's first word |
| hd_eop | input | 1 | Head word is a packet's last word |
| hd_mod | input | 2 | Byte modulo of the head word |
| hd_err | input | 1 | Packet error marker of the head word |
| renb_n | input | 1 | Read enable from the link layer, active low |
| rx_dat | output | 32 | Bus data or port address |
| rx_prty | output | 1 | Odd parity over `rx_dat` |
| rx_mod | output | 2 | Valid-byte modulo |
| rx_sop | output | 1 | Start of packet |
| rx_eop | output | 1 | End of packet |
| rx_err | output | 1 | Packet error |
| rx_sx | output | 1 | Address cycle marker |
| rx_val | output | 1 | Data valid |

## Verification
The burst-limit stop and the packet-end stop can fall on the same word. The bench provokes this with a 16-byte packet under a four-word limit. The scheduler must close the burst once, with packet end on the fourth word, and must not open a second address cycle for that port. A freeze from `renb_n` can also land in the middle of a burst. The bench checks that the outputs stay constant through the freeze and that the word indices that follow show no lost or repeated word.

// File: rtl/rx_burst_pkg.sv
`timescale 1ns/1ps
package rx_burst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_GAP} sched_st_t;

  // Bit that makes the total count of ones in {w, bit} odd.
  function automatic logic odd_fill(input logic [31:0] w);
    return ~^w;
  endfunction
endpackage

// File: rtl/rx_port_elig.sv
`timescale 1ns/1ps
module rx_port_elig #(
  parameter int NPORTS = 4,
  parameter int CNTW   = 9
) (
  input  logic [NPORTS*CNTW-1:0] port_bytes,
  input  logic [CNTW-1:0]        thresh,
  input  logic [NPORTS-1:0]      has_eop,
  output logic [NPORTS-1:0]      elig
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign elig[p] = (port_bytes[p*CNTW +: CNTW] > thresh) || has_eop[p];
  end
endmodule

// File: rtl/rx_rr_pick.sv
`timescale 1ns/1ps
module rx_rr_pick #(
  parameter int NPORTS = 4,
  parameter int PW     = 2
) (
  input  logic [NPORTS-1:0] req,
  input  logic [PW-1:0]     ptr,
  output logic [PW-1:0]     gnt,
  output logic              any
);
  int idx;
  // Scan from the farthest offset down so the nearest request wins.
  always_comb begin
    any = 1'b0;
    gnt = '0;
    idx = 0;
    for (int k = NPORTS - 1; k >= 0; k--) begin
      idx = int'(ptr) + k;
      if (idx >= NPORTS) idx = idx - NPORTS;
      if (req[idx]) begin
        any = 1'b1;
        gnt = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/rx_burst_sched.sv
`timescale 1ns/1ps
module rx_burst_sched
  import rx_burst_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int CNTW   = 9,
  parameter int MAXW   = 64,
  localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int LIMW  = $clog2(MAXW) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNTW-1:0]        cfg_thresh,
  input  logic [LIMW-1:0]        cfg_burst_words,
  input  logic                   cfg_gap2,
  input  logic [NPORTS*CNTW-1:0] port_bytes,
  input  logic [NPORTS-1:0]      port_has_eop,
  output logic [PW-1:0]          rd_port,
  input  logic                   hd_valid,
  output logic                   hd_ready,
  input  logic [31:0]            hd_data,
  input  logic                   hd_sop,
  input  logic                   hd_eop,
  input  logic [1:0]             hd_mod,
  input  logic                   hd_err,
  input  logic                   renb_n,
  output logic [31:0]            rx_dat,
  output logic                   rx_prty,
  output logic [1:0]             rx_mod,
  output logic                   rx_sop,
  output logic                   rx_eop,
  output logic                   rx_err,
  output logic                   rx_sx,
  output logic                   rx_val
);
  logic [NPORTS-1:0] elig;
  logic [PW-1:0]     ptr_q, sel_q, gnt;
  logic              any;
  sched_st_t         st_q;
  logic [LIMW-1:0]   wcnt_q, lim, wnext;
  logic [1:0]        gcnt_q;
  logic              close_burst;

  rx_port_elig #(.NPORTS(NPORTS), .CNTW(CNTW)) elig_i (
    .port_bytes(port_bytes), .thresh(cfg_thresh),
    .has_eop(port_has_eop), .elig(elig)
  );

  rx_rr_pick #(.NPORTS(NPORTS), .PW(PW)) pick_i (
    .req(elig), .ptr(ptr_q), .gnt(gnt), .any(any)
  );

  assign lim         = (cfg_burst_words == '0) ? LIMW'(MAXW) : cfg_burst_words;
  assign wnext       = wcnt_q + 1'b1;
  assign close_burst = hd_eop || (wnext >= lim);
  assign rd_port     = sel_q;
  assign hd_ready    = !renb_n && (st_q == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      sel_q   <= '0;
      wcnt_q  <= '0;
      gcnt_q  <= '0;
      rx_dat  <= '0;
      rx_prty <= 1'b0;
      rx_mod  <= '0;
      rx_sop  <= 1'b0;
      rx_eop  <= 1'b0;
      rx_err  <= 1'b0;
      rx_sx   <= 1'b0;
      rx_val  <= 1'b0;
    end else if (!renb_n) begin
      case (st_q)
        ST_IDLE: begin
          rx_val <= 1'b0;
          rx_sop <= 1'b0;
          rx_eop <= 1'b0;
          rx_err <= 1'b0;
          rx_mod <= '0;
          rx_sx  <= any;
          if (any) begin
            rx_dat  <= 32'(gnt);
            rx_prty <= odd_fill(32'(gnt));
            sel_q   <= gnt;
            wcnt_q  <= '0;
            st_q    <= ST_DATA;
          end
        end
        ST_DATA: begin
          rx_sx  <= 1'b0;
          rx_val <= hd_valid;
          if (hd_valid) begin
            rx_dat  <= hd_data;
            rx_prty <= odd_fill(hd_data);
            rx_sop  <= hd_sop;
            rx_eop  <= hd_eop;
            rx_mod  <= hd_eop ? hd_mod : 2'b00;
            rx_err  <= hd_eop && hd_err;
            wcnt_q  <= wnext;
            if (close_burst) begin
              ptr_q  <= (sel_q == PW'(NPORTS - 1)) ? '0 : sel_q + 1'b1;
              gcnt_q <= 2'd2;
              st_q   <= cfg_gap2 ? ST_GAP : ST_IDLE;
            end
          end
        end
        default: begin
          rx_sx  <= 1'b0;
          rx_val <= 1'b0;
          gcnt_q <= gcnt_q - 1'b1;
          if (gcnt_q <= 2'd1) st_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_burst_sched_chk.sv
`timescale 1ns/1ps
module rx_burst_sched_chk #(
  parameter int MAXW = 64,
  localparam int LIMW = $clog2(MAXW) + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            renb_n,
  input logic [LIMW-1:0] cfg_burst_words,
  input logic            hd_ready,
  input logic [31:0]     rx_dat,
  input logic            rx_prty,
  input logic [1:0]      rx_mod,
  input logic            rx_sop,
  input logic            rx_eop,
  input logic            rx_err,
  input logic            rx_sx,
  input logic            rx_val
);
  logic            ren_q;
  logic [LIMW:0]   cnt_q;
  logic [LIMW:0]   lim;

  assign lim = (cfg_burst_words == '0) ? (LIMW+1)'(MAXW) : {1'b0, cfg_burst_words};

  // ren_q marks output values that a real read edge produced.
  always_ff @(posedge clk) begin
    if (rst) begin
      ren_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ren_q <= !renb_n;
      if (ren_q && rx_sx) cnt_q <= '0;
      else if (ren_q && rx_val) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_addr_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    rx_sx |-> (!rx_val && rx_dat[31:8] == 24'd0));
  assert_eop_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (ren_q && rx_val && rx_eop && !renb_n) |=> !rx_val);
  assert_burst_cap_R3: assert property (@(posedge clk) disable iff (rst)
    (ren_q && rx_val) |-> (cnt_q < lim));
  assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    renb_n |=> ($stable(rx_dat) && $stable(rx_val) && $stable(rx_sx) &&
                $stable(rx_sop) && $stable(rx_eop) && $stable(rx_mod) &&
                $stable(rx_err) && $stable(rx_prty)));
  assert_mod_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_val && !rx_eop) |-> (rx_mod == 2'b00));
  assert_err_at_eop_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_val && rx_err) |-> rx_eop);
  assert_odd_parity_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_val || rx_sx) |-> (^{rx_dat, rx_prty} == 1'b1));
  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (!rx_val && !rx_sx));
  assert_no_take_held_R12: assert property (@(posedge clk) disable iff (rst)
    renb_n |-> !hd_ready);
endmodule

bind rx_burst_sched rx_burst_sched_chk #(.MAXW(MAXW)) chk_i (.*);

// File: tb/rx_burst_sched_tb_top.sv
`timescale 1ns/1ps
module rx_burst_sched_tb_top;
  localparam int NP = 4;
  localparam int CW = 9;
  // {port[15:12], bytes[11:4], err[3:0]}
  localparam logic [15:0] VEC [6] = '{
    {4'd0, 8'd1,  4'd0}, {4'd3, 8'd4,  4'd0}, {4'd1, 8'd7,  4'd1},
    {4'd2, 8'd10, 4'd0}, {4'd3, 8'd13, 4'd0}, {4'd0, 8'd64, 4'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [CW-1:0]    cfg_thresh = 9'd511;
  logic [6:0]       cfg_burst_words = 7'd64;
  logic             cfg_gap2 = 1'b0;
  logic [NP*CW-1:0] port_bytes;
  logic [NP-1:0]    port_has_eop;
  logic [1:0]       rd_port;
  logic             hd_valid, hd_ready, hd_sop, hd_eop, hd_err;
  logic [31:0]      hd_data;
  logic [1:0]       hd_mod;
  logic             renb_n = 1'b0;
  logic [31:0]      rx_dat;
  logic             rx_prty, rx_sop, rx_eop, rx_err, rx_sx, rx_val;
  logic [1:0]       rx_mod;

  int n_chk = 0, n_bad = 0, cyc = 0, lc = 0;
  logic ren_q = 1'b0;
  logic [36:0] mem [NP][64];
  int wp[NP], rp[NP], pb[NP], qb[NP], pe[NP], qe[NP];
  logic [31:0] l_dat [1024];
  logic        l_sx [1024], l_val [1024], l_sop [1024], l_eop [1024], l_err [1024], l_prty [1024];
  logic [1:0]  l_mod [1024];
  int          l_cyc [1024];
  logic [36:0] head;

  rx_burst_sched #(.NPORTS(NP), .CNTW(CW), .MAXW(64)) dut_i (
    .clk(clk), .rst(rst), .cfg_thresh(cfg_thresh), .cfg_burst_words(cfg_burst_words),
    .cfg_gap2(cfg_gap2), .port_bytes(port_bytes), .port_has_eop(port_has_eop),
    .rd_port(rd_port), .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_data(hd_data),
    .hd_sop(hd_sop), .hd_eop(hd_eop), .hd_mod(hd_mod), .hd_err(hd_err),
    .renb_n(renb_n), .rx_dat(rx_dat), .rx_prty(rx_prty), .rx_mod(rx_mod),
    .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err), .rx_sx(rx_sx), .rx_val(rx_val)
  );

  // Bench-side FIFO model: word = {sop, eop, mod[1:0], err, data[31:0]}
  assign head     = mem[rd_port][rp[rd_port] & 63];
  assign hd_valid = wp[rd_port] != rp[rd_port];
  assign {hd_sop, hd_eop, hd_mod, hd_err, hd_data} = head;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      port_bytes[p*CW +: CW] = CW'(pb[p] - qb[p]);
      port_has_eop[p]        = pe[p] != qe[p];
    end
  end

  function automatic int wbytes(input logic [36:0] w);
    if (!w[35]) return 4;
    return (w[34:33] == 2'b00) ? 4 : 4 - int'(w[34:33]);
  endfunction

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    ren_q <= !renb_n;
    if (hd_valid && hd_ready) begin
      rp[rd_port] <= rp[rd_port] + 1;
      qb[rd_port] <= qb[rd_port] + wbytes(head);
      if (head[35]) qe[rd_port] <= qe[rd_port] + 1;
    end
  end

  always @(negedge clk) begin
    if (ren_q && (rx_sx || rx_val) && lc < 1024) begin
      l_dat[lc] = rx_dat;  l_sx[lc] = rx_sx;   l_val[lc] = rx_val;
      l_sop[lc] = rx_sop;  l_eop[lc] = rx_eop; l_err[lc] = rx_err;
      l_mod[lc] = rx_mod;  l_prty[lc] = rx_prty; l_cyc[lc] = cyc;
      lc = lc + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_seg(input int port, input int nw, input bit first, input bit last,
                          input int lastb, input bit err, input int id);
    for (int i = 0; i < nw; i++) begin
      logic e;
      e = last && (i == nw - 1);
      mem[port][wp[port] & 63] = {first && (i == 0), e, e ? 2'((4 - lastb) & 3) : 2'b00,
                                  e && err, 4'hA, 4'(port), 8'(id), 8'(i), 8'h5A};
      wp[port] = wp[port] + 1;
    end
    pb[port] = pb[port] + (nw - 1) * 4 + (last ? lastb : 4);
    if (last) pe[port] = pe[port] + 1;
  endtask

  task automatic push_pkt(input int port, input int n, input bit err, input int id);
    int nw;
    nw = (n + 3) / 4;
    push_seg(port, nw, 1'b1, 1'b1, n - 4 * (nw - 1), err, id);
  endtask

  task automatic wait_log(input int n, input string tag);
    int t;
    t = 0;
    while (lc < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (lc < n) chk(1'b0, tag, lc, n);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R3 watchdog expired", 1, 0);
    summary();
  end

  initial begin
    int s;
    logic [39:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rx_val && !rx_sx, "R11 outputs low after reset", {rx_val, rx_sx}, 0);

    // Table walk: one packet at a time, eop-only eligibility.
    for (int v = 0; v < 6; v++) begin
      int port, n, nw, exmod, bad_sop, bad_eop, bad_par, bad_tag;
      bit er;
      port = int'(VEC[v][15:12]); n = int'(VEC[v][11:4]); er = VEC[v][0];
      nw = (n + 3) / 4; exmod = (4 - (n % 4)) % 4;
      s = lc;
      push_pkt(port, n, er, v);
      wait_log(s + 1 + nw, "R3 burst words");
      repeat (6) @(negedge clk);
      chk(lc == s + 1 + nw, "R3 burst length", lc - s, 1 + nw);
      chk(l_sx[s] && !l_val[s] && l_dat[s] == 32'(port), "R2 address cycle", int'(l_dat[s]), port);
      bad_sop = 0; bad_eop = 0; bad_par = 0; bad_tag = 0;
      for (int i = 0; i <= nw; i++) begin
        if (^{l_dat[s+i], l_prty[s+i]} != 1'b1) bad_par++;
        if (i > 0) begin
          if (l_sop[s+i] != (i == 1)) bad_sop++;
          if (i < nw && (l_eop[s+i] || l_mod[s+i] != 2'b00 || l_err[s+i])) bad_eop++;
          if (l_dat[s+i][31:24] != {4'hA, 4'(port)}) bad_tag++;
        end
      end
      chk(bad_par == 0, "R9 odd parity", bad_par, 0);
      chk(bad_sop == 0, "R8 sop on first word only", bad_sop, 0);
      chk(bad_eop == 0, "R7 mod zero before packet end", bad_eop, 0);
      chk(bad_tag == 0, "R3 data from selected port", bad_tag, 0);
      chk(l_eop[s+nw] && int'(l_mod[s+nw]) == exmod, "R7 end modulo", int'(l_mod[s+nw]), exmod);
      chk(l_err[s+nw] == er, "R8 error on end word", int'(l_err[s+nw]), int'(er));
    end

    // Round robin: pointer now 1.
    s = lc;
    push_pkt(0, 4, 0, 10); push_pkt(2, 4, 0, 11); push_pkt(3, 4, 0, 12);
    wait_log(s + 6, "R3 round robin");
    chk(l_dat[s] == 2 && l_dat[s+2] == 3 && l_dat[s+4] == 0, "R3 order 2,3,0",
        int'(l_dat[s]), 2);
    s = lc; push_pkt(2, 4, 0, 13); wait_log(s + 2, "R3 single");
    s = lc; push_pkt(0, 4, 0, 14); push_pkt(3, 4, 0, 15);
    wait_log(s + 4, "R3 wrap");
    chk(l_dat[s] == 3 && l_dat[s+2] == 0, "R3 order 3 before 0", int'(l_dat[s]), 3);

    // Reset returns pointer to port 0 (pointer was 1).
    repeat (4) @(negedge clk);
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk(!rx_val && !rx_sx, "R11 outputs low after second reset", {rx_val, rx_sx}, 0);
    s = lc; push_pkt(3, 4, 0, 16); push_pkt(0, 4, 0, 17);
    wait_log(s + 4, "R11 pointer");
    chk(l_dat[s] == 0, "R11 pointer at port 0", int'(l_dat[s]), 0);

    // Burst limit, continuation, and limit coinciding with packet end.
    cfg_burst_words = 7'd4;
    s = lc; push_pkt(2, 24, 0, 20);
    wait_log(s + 8, "R3 limit");
    chk(l_sx[s+5] && l_dat[s+5] == 2, "R3 limit reopens burst", int'(l_sx[s+5]), 1);
    chk(!l_eop[s+4], "R3 no end at cut", int'(l_eop[s+4]), 0);
    chk(l_sop[s+1] && !l_sop[s+6], "R10 sop only on true first word", int'(l_sop[s+6]), 0);
    chk(l_eop[s+7], "R10 continuation ends packet", int'(l_eop[s+7]), 1);
    s = lc; push_pkt(2, 16, 0, 21);
    wait_log(s + 5, "R3 coincide");
    repeat (8) @(negedge clk);
    chk(lc == s + 5 && l_eop[s+4], "R3 limit and end on same word", lc - s, 5);
    cfg_burst_words = 7'd64;

    // Threshold boundary and empty mid-burst resume.
    cfg_thresh = 9'd12;
    s = lc; push_seg(1, 3, 1'b1, 1'b0, 4, 1'b0, 30);
    repeat (20) @(negedge clk);
    chk(lc == s, "R1 count equal to threshold not served", lc - s, 0);
    push_seg(1, 1, 1'b0, 1'b0, 4, 1'b0, 31);
    wait_log(s + 5, "R1 above threshold");
    chk(l_sx[s] && l_dat[s] == 1, "R1 served above threshold", int'(l_dat[s]), 1);
    repeat (5) @(negedge clk);
    chk(!rx_val && lc == s + 5, "R5 valid low on empty", int'(rx_val), 0);
    push_seg(1, 1, 1'b0, 1'b1, 1, 1'b0, 32);
    wait_log(s + 6, "R5 resume");
    chk(!l_sx[s+5] && l_val[s+5] && l_eop[s+5], "R5 resume without address", int'(l_sx[s+5]), 0);
    chk(l_mod[s+5] == 2'b11, "R7 one valid byte modulo", int'(l_mod[s+5]), 3);
    cfg_thresh = 9'd511;

    // Freeze mid-burst.
    repeat (4) @(negedge clk);
    s = lc; push_pkt(2, 20, 0, 40);
    wait_log(s + 3, "R4 start");
    renb_n = 1'b1;
    snap = {rx_dat, rx_prty, rx_mod, rx_sop, rx_eop, rx_err, rx_sx, rx_val};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(snap == {rx_dat, rx_prty, rx_mod, rx_sop, rx_eop, rx_err, rx_sx, rx_val},
          "R4 outputs held", int'(rx_dat[15:8]), int'(snap[23:16]));
      chk(!hd_ready, "R12 no take while held", int'(hd_ready), 0);
    end
    renb_n = 1'b0;
    wait_log(s + 6, "R4 finish");
    begin
      int bad;
      bad = 0;
      for (int i = 1; i <= 5; i++) if (int'(l_dat[s+i][15:8]) != i - 1) bad++;
      chk(bad == 0, "R4 no word lost or repeated", bad, 0);
    end

    // Inter-burst gap.
    repeat (6) @(negedge clk);
    s = lc; push_pkt(1, 4, 0, 50); push_pkt(3, 4, 0, 51);
    wait_log(s + 4, "R6 gap0");
    chk(l_cyc[s+2] - l_cyc[s+1] == 1, "R6 zero gap", l_cyc[s+2] - l_cyc[s+1], 1);
    cfg_gap2 = 1'b1;
    repeat (6) @(negedge clk);
    s = lc; push_pkt(1, 4, 0, 52); push_pkt(3, 4, 0, 53);
    wait_log(s + 4, "R6 gap2");
    chk(l_cyc[s+2] - l_cyc[s+1] == 3, "R6 two idle cycles", l_cyc[s+2] - l_cyc[s+1], 3);

    summary();
  end
endmodule